// File: doc/BRIEF.md
# Coarse Tile Depth Rejection Unit

This block holds a small on-chip store of 16-bit depth bounds, one entry per 8x8 pixel tile of the render target. For each primitive that touches a tile, the rasterizer front end presents the tile coordinates, the smallest and largest depth the primitive reaches inside that tile, and the active depth compare function. The unit reads the stored bound for the tile and decides whether every fragment of the primitive in that tile is certain to fail the depth test. If so, the tile can be dropped before per-pixel work starts.

The stored bound is conservative. For the "less" family of compare functions it is an upper limit on the depth already in the tile and it only moves down. For the "greater" family it is a lower limit and it only moves up. A bound is tightened only when the primitive covers the whole tile, passes the coarse test, writes depth, and has neither blending nor stencil enabled, since a hidden fragment can still change the colour in those cases. Incoming depths are wider than 16 bits and are rounded in the direction that can never cause a visible fragment to be discarded. A clear command fills every entry with a programmable value. The store has one row per tile row, and each row is as wide as the tile columns rounded up to a multiple of 32 entries.

Top module: `lrz_unit`

## Requirements
- R1: While reset is held and just after it is released, `req_ready_o` is 1, `busy_o` is 0 and `resp_valid_o` is 0.
- R2: A request accepted at a clock edge (`req_valid_i` and `req_ready_o` both 1) gives `resp_valid_o` = 1 with its `discard_o` exactly two edges later. No response appears in any other cycle.
- R3: Compare codes 0 (never), 2 (equal), 5 (not equal) and 7 (always) never give a discard and never change a stored bound.
- R4: With code 1 (less) a request is discarded when its rounded minimum depth is greater than or equal to the stored bound. With code 3 (less or equal) it is discarded when that minimum is strictly greater than the bound.
- R5: With code 4 (greater) a request is discarded when its rounded maximum depth is less than or equal to the stored bound. With code 6 (greater or equal) it is discarded when that maximum is strictly less than the bound.
- R6: The 24-bit minimum depth is rounded down to its top 16 bits. The 24-bit maximum depth is rounded up: the top 16 bits plus one when any lower bit is set, saturating at 0xFFFF.
- R7: A bound update sets the entry to min(bound, rounded maximum) for codes 1 and 3, and to max(bound, rounded minimum) for codes 4 and 6.
- R8: A bound is updated only when the request is not discarded, `full_cover_i` = 1, `wr_en_i` = 1, `blend_en_i` = 0 and `stencil_en_i` = 0.
- R9: A clear is taken when `clear_i` = 1 and `busy_o` = 0. Every entry then holds `clear_val_i`. `busy_o` stays high for exactly one cycle per entry (rows x row pitch, with the pitch equal to the columns rounded up to a multiple of 32). `req_ready_o` is 0 while `busy_o` is 1 and in any cycle where `clear_i` is 1.
- R10: A request accepted one cycle after a request to the same tile is tested against the bound that the earlier request wrote.
- R11: Tiles are independent. A bound update to one tile does not change the outcome for any other tile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request can be accepted this cycle |
| tile_x_i | input | 6 | Tile column |
| tile_y_i | input | 2 | Tile row |
| zmin_i | input | 24 | Smallest primitive depth in the tile |
| zmax_i | input | 24 | Largest primitive depth in the tile |
| full_cover_i | input | 1 | Primitive covers the whole tile |
| zfunc_i | input | 3 | Depth compare code (0 never, 1 less, 2 equal, 3 less-equal, 4 greater, 5 not-equal, 6 greater-equal, 7 always) |
| wr_en_i | input | 1 | Depth writes enabled |
| blend_en_i | input | 1 | Blending enabled |
| stencil_en_i | input | 1 | Stencil enabled |
| clear_i | input | 1 | Start a clear of the whole store |
| clear_val_i | input | 16 | Value written by a clear |
| busy_o | output | 1 | Clear in progress |
| resp_valid_o | output | 1 | Decision present |
| discard_o | output | 1 | Tile may be dropped |

## Verification
A request is accepted at one rising edge, its bound is read at that edge, and its decision is registered at the second edge after acceptance. The bench therefore drives inputs on falling edges and checks `resp_valid_o` low half a cycle after the accepting edge and high, together with `discard_o`, half a cycle after the next edge. Bound updates are never read directly. They are observed through the decision of a later probe request to the same tile, chosen so that the old and new bound give different answers. A clear is timed by counting the falling edges at which `busy_o` is high, and `req_ready_o` is sampled shortly after `clear_i` rises within the same cycle.

// File: rtl/lrz_pkg.sv
`timescale 1ns/1ps
package lrz_pkg;
  localparam int unsigned CZW = 16;
  typedef logic [CZW-1:0] cz_t;

  typedef enum logic [2:0] {
    ZF_NEVER    = 3'd0,
    ZF_LESS     = 3'd1,
    ZF_EQUAL    = 3'd2,
    ZF_LEQUAL   = 3'd3,
    ZF_GREATER  = 3'd4,
    ZF_NOTEQUAL = 3'd5,
    ZF_GEQUAL   = 3'd6,
    ZF_ALWAYS   = 3'd7
  } zfunc_e;
endpackage

// File: rtl/lrz_quant.sv
`timescale 1ns/1ps
module lrz_quant
  import lrz_pkg::*;
#(
  parameter int unsigned DW      = 24,
  parameter bit          ROUND_UP = 1'b0
) (
  input  logic [DW-1:0] z_i,
  output cz_t           zq_o
);
  localparam int unsigned FW = (DW > CZW) ? DW - CZW : 1;

  generate
    if (DW == CZW) begin : g_pass
      assign zq_o = z_i;
    end else if (ROUND_UP) begin : g_ceil
      cz_t top;
      logic frac_nz;
      assign top     = z_i[DW-1 -: CZW];
      assign frac_nz = |z_i[FW-1:0];
      // saturate instead of wrapping to zero
      assign zq_o    = (frac_nz && top != '1) ? top + 1'b1 : top;
    end else begin : g_floor
      logic unused_frac;
      assign unused_frac = ^z_i[FW-1:0];
      assign zq_o        = z_i[DW-1 -: CZW];
    end
  endgenerate
endmodule

// File: rtl/lrz_store.sv
`timescale 1ns/1ps
module lrz_store
  import lrz_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_en_i,
  input  logic [AW-1:0] rd_addr_i,
  output cz_t           rd_data_o,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  cz_t           wr_data_i,
  input  logic          clr_start_i,
  input  cz_t           clr_val_i,
  output logic          busy_o
);
  cz_t           mem [DEPTH];
  cz_t           clr_q;
  logic [AW-1:0] clr_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o    <= 1'b0;
      clr_cnt_q <= '0;
      clr_q     <= '0;
    end else if (busy_o) begin
      clr_cnt_q <= clr_cnt_q + 1'b1;
      if (clr_cnt_q == AW'(DEPTH - 1)) busy_o <= 1'b0;
    end else if (clr_start_i) begin
      busy_o    <= 1'b1;
      clr_cnt_q <= '0;
      clr_q     <= clr_val_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (busy_o) mem[clr_cnt_q] <= clr_q;
    else if (wr_en_i) mem[wr_addr_i] <= wr_data_i;
    if (rd_en_i) rd_data_o <= mem[rd_addr_i];
  end
endmodule

// File: rtl/lrz_decide.sv
`timescale 1ns/1ps
module lrz_decide
  import lrz_pkg::*;
(
  input  logic [2:0] zfunc_i,
  input  cz_t        bound_i,
  input  cz_t        zlo_i,
  input  cz_t        zhi_i,
  input  logic       full_cover_i,
  input  logic       wr_en_i,
  input  logic       blend_en_i,
  input  logic       stencil_en_i,
  output logic       discard_o,
  output logic       upd_o,
  output cz_t        upd_val_o
);
  zfunc_e fn;
  logic   ordered, gt_sense;

  assign fn       = zfunc_e'(zfunc_i);
  assign ordered  = fn inside {ZF_LESS, ZF_LEQUAL, ZF_GREATER, ZF_GEQUAL};
  assign gt_sense = fn inside {ZF_GREATER, ZF_GEQUAL};

  always_comb begin
    unique case (fn)
      ZF_LESS:    discard_o = zlo_i >= bound_i;
      ZF_LEQUAL:  discard_o = zlo_i >  bound_i;
      ZF_GREATER: discard_o = zhi_i <= bound_i;
      ZF_GEQUAL:  discard_o = zhi_i <  bound_i;
      default:    discard_o = 1'b0;
    endcase
  end

  assign upd_o = ordered && !discard_o && full_cover_i && wr_en_i &&
                 !blend_en_i && !stencil_en_i;

  // far side of a covering primitive tightens the bound
  assign upd_val_o = gt_sense ? ((zlo_i > bound_i) ? zlo_i : bound_i)
                              : ((zhi_i < bound_i) ? zhi_i : bound_i);
endmodule

// File: rtl/lrz_unit.sv
`timescale 1ns/1ps
module lrz_unit
  import lrz_pkg::*;
#(
  parameter int unsigned TILES_X = 40,
  parameter int unsigned TILES_Y = 4,
  parameter int unsigned DW      = 24,
  localparam int unsigned XW     = (TILES_X > 1) ? $clog2(TILES_X) : 1,
  localparam int unsigned YW     = (TILES_Y > 1) ? $clog2(TILES_Y) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [XW-1:0] tile_x_i,
  input  logic [YW-1:0] tile_y_i,
  input  logic [DW-1:0] zmin_i,
  input  logic [DW-1:0] zmax_i,
  input  logic          full_cover_i,
  input  logic [2:0]    zfunc_i,
  input  logic          wr_en_i,
  input  logic          blend_en_i,
  input  logic          stencil_en_i,
  input  logic          clear_i,
  input  logic [15:0]   clear_val_i,
  output logic          busy_o,
  output logic          resp_valid_o,
  output logic          discard_o
);
  localparam int unsigned PITCH = ((TILES_X + 31) / 32) * 32;
  localparam int unsigned DEPTH = PITCH * TILES_Y;
  localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic          accept, clr_start;
  logic [AW-1:0] req_addr;
  cz_t           zlo_q, zhi_q;

  logic          s1_vld;
  logic [AW-1:0] s1_addr;
  cz_t           s1_zlo, s1_zhi;
  logic [2:0]    s1_fn;
  logic          s1_full, s1_wr, s1_blend, s1_sten;

  logic          fwd_vld;
  logic [AW-1:0] fwd_addr;
  cz_t           fwd_val;

  cz_t           rd_data, bound;
  logic          dec_discard, dec_upd, st_we;
  cz_t           dec_val;

  assign req_ready_o = !busy_o && !clear_i;
  assign accept      = req_valid_i && req_ready_o;
  assign clr_start   = clear_i && !busy_o;
  assign req_addr    = AW'(tile_y_i) * AW'(PITCH) + AW'(tile_x_i);

  lrz_quant #(.DW(DW), .ROUND_UP(1'b0)) u_q_lo (.z_i(zmin_i), .zq_o(zlo_q));
  lrz_quant #(.DW(DW), .ROUND_UP(1'b1)) u_q_hi (.z_i(zmax_i), .zq_o(zhi_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld   <= 1'b0;
      s1_addr  <= '0;
      s1_zlo   <= '0;
      s1_zhi   <= '0;
      s1_fn    <= '0;
      s1_full  <= 1'b0;
      s1_wr    <= 1'b0;
      s1_blend <= 1'b0;
      s1_sten  <= 1'b0;
    end else begin
      s1_vld <= accept;
      if (accept) begin
        s1_addr  <= req_addr;
        s1_zlo   <= zlo_q;
        s1_zhi   <= zhi_q;
        s1_fn    <= zfunc_i;
        s1_full  <= full_cover_i;
        s1_wr    <= wr_en_i;
        s1_blend <= blend_en_i;
        s1_sten  <= stencil_en_i;
      end
    end
  end

  lrz_store #(.DEPTH(DEPTH)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_en_i     (accept),
    .rd_addr_i   (req_addr),
    .rd_data_o   (rd_data),
    .wr_en_i     (st_we),
    .wr_addr_i   (s1_addr),
    .wr_data_i   (dec_val),
    .clr_start_i (clr_start),
    .clr_val_i   (clear_val_i),
    .busy_o      (busy_o)
  );

  // read and write of the same entry share an edge; bypass the stale read
  assign bound = (fwd_vld && fwd_addr == s1_addr) ? fwd_val : rd_data;

  lrz_decide u_decide (
    .zfunc_i      (s1_fn),
    .bound_i      (bound),
    .zlo_i        (s1_zlo),
    .zhi_i        (s1_zhi),
    .full_cover_i (s1_full),
    .wr_en_i      (s1_wr),
    .blend_en_i   (s1_blend),
    .stencil_en_i (s1_sten),
    .discard_o    (dec_discard),
    .upd_o        (dec_upd),
    .upd_val_o    (dec_val)
  );

  assign st_we = s1_vld && dec_upd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fwd_vld      <= 1'b0;
      fwd_addr     <= '0;
      fwd_val      <= '0;
      resp_valid_o <= 1'b0;
      discard_o    <= 1'b0;
    end else begin
      fwd_vld      <= st_we;
      fwd_addr     <= s1_addr;
      fwd_val      <= dec_val;
      resp_valid_o <= s1_vld;
      discard_o    <= s1_vld && dec_discard;
    end
  end
endmodule

// File: rtl/lrz_unit_chk.sv
`timescale 1ns/1ps
module lrz_unit_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_valid_i,
  input logic       req_ready_o,
  input logic [2:0] zfunc_i,
  input logic       blend_en_i,
  input logic       stencil_en_i,
  input logic       clear_i,
  input logic       busy_o,
  input logic       resp_valid_o,
  input logic       discard_o,
  input logic       mem_we
);
  // R2
  resp_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |-> ##2 resp_valid_o);

  // R2
  resp_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> $past(req_valid_i && req_ready_o, 2));

  // R3
  unordered_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && (zfunc_i inside {3'd0, 3'd2, 3'd5, 3'd7}))
      |-> ##2 !discard_o);

  // R8
  blend_nowrite_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && (blend_en_i || stencil_en_i)) |=> !mem_we);

  // R9
  busy_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o || clear_i) |-> !req_ready_o);

  // R9
  clear_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && !busy_o) |=> busy_o);
endmodule

bind lrz_unit lrz_unit_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .zfunc_i      (zfunc_i),
  .blend_en_i   (blend_en_i),
  .stencil_en_i (stencil_en_i),
  .clear_i      (clear_i),
  .busy_o       (busy_o),
  .resp_valid_o (resp_valid_o),
  .discard_o    (discard_o),
  .mem_we       (st_we)
);

// File: tb/lrz_unit_tb.sv
`timescale 1ns/1ps
module lrz_unit_tb;
  localparam int NV    = 24;
  localparam int DEPTH = 256;  // 4 rows x pitch 64

  typedef struct packed {
    logic [5:0]  x;
    logic [1:0]  y;
    logic [23:0] zmin;
    logic [23:0] zmax;
    logic        full;
    logic [2:0]  fn;
    logic        wr;
    logic        blend;
    logic        sten;
    logic        exp_disc;
  } vec_t;

  // all tiles start at 0x8000
  localparam vec_t VECS [NV] = '{
    '{6'd0,  2'd0, 24'h600000, 24'h6FFF01, 1'b1, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0}, // R7 bound->7000
    '{6'd0,  2'd0, 24'h700000, 24'h750000, 1'b0, 3'd1, 1'b1, 1'b0, 1'b0, 1'b1}, // R4 equal rejects
    '{6'd0,  2'd0, 24'h700000, 24'h780000, 1'b1, 3'd3, 1'b1, 1'b0, 1'b0, 1'b0}, // R4 leq passes
    '{6'd0,  2'd0, 24'h7000FF, 24'h7000FF, 1'b0, 3'd3, 1'b1, 1'b0, 1'b0, 1'b0}, // R6 floor
    '{6'd1,  2'd0, 24'h500000, 24'h5FFFFF, 1'b1, 3'd1, 1'b1, 1'b1, 1'b0, 1'b0}, // R8 blend
    '{6'd1,  2'd0, 24'h600000, 24'h600000, 1'b0, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0}, // R8 probe
    '{6'd1,  2'd0, 24'h400000, 24'h500000, 1'b1, 3'd1, 1'b1, 1'b0, 1'b1, 1'b0}, // R8 stencil
    '{6'd1,  2'd0, 24'h600000, 24'h600000, 1'b0, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0}, // R8 probe
    '{6'd1,  2'd0, 24'h400000, 24'h500000, 1'b1, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0}, // R8 no wr
    '{6'd1,  2'd0, 24'h600000, 24'h600000, 1'b0, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0}, // R8 probe
    '{6'd1,  2'd0, 24'h400000, 24'h500000, 1'b0, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0}, // R8 partial
    '{6'd1,  2'd0, 24'h600000, 24'h600000, 1'b0, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0}, // R8 probe
    '{6'd39, 2'd3, 24'h900000, 24'h9000FF, 1'b1, 3'd4, 1'b1, 1'b0, 1'b0, 1'b0}, // R7 bound->9000
    '{6'd39, 2'd3, 24'h800000, 24'h8FFF01, 1'b0, 3'd4, 1'b1, 1'b0, 1'b0, 1'b1}, // R5 R6 ceil
    '{6'd39, 2'd3, 24'h800000, 24'h8FFF01, 1'b0, 3'd6, 1'b1, 1'b0, 1'b0, 1'b0}, // R5 geq pass
    '{6'd39, 2'd3, 24'h800000, 24'h8FFF00, 1'b0, 3'd6, 1'b1, 1'b0, 1'b0, 1'b1}, // R5 geq reject
    '{6'd39, 2'd3, 24'h100000, 24'h100000, 1'b1, 3'd7, 1'b1, 1'b0, 1'b0, 1'b0}, // R3 always
    '{6'd39, 2'd3, 24'h800000, 24'h8FFF01, 1'b0, 3'd4, 1'b1, 1'b0, 1'b0, 1'b1}, // R3 probe
    '{6'd39, 2'd3, 24'h100000, 24'h100000, 1'b1, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0}, // R3 never
    '{6'd39, 2'd3, 24'h100000, 24'h100000, 1'b1, 3'd2, 1'b1, 1'b0, 1'b0, 1'b0}, // R3 equal
    '{6'd39, 2'd3, 24'hF00000, 24'hF00000, 1'b1, 3'd5, 1'b1, 1'b0, 1'b0, 1'b0}, // R3 not-equal
    '{6'd2,  2'd1, 24'h7F0000, 24'h7F0000, 1'b1, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0}, // R11 bound->7F00
    '{6'd2,  2'd0, 24'h7F0000, 24'h7F0000, 1'b0, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0}, // R11 neighbour
    '{6'd2,  2'd1, 24'h7F0000, 24'h7F0000, 1'b0, 3'd1, 1'b1, 1'b0, 1'b0, 1'b1}  // R11 same tile
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [5:0]  tile_x = '0;
  logic [1:0]  tile_y = '0;
  logic [23:0] zmin = '0, zmax = '0;
  logic        full_cover = 1'b0;
  logic [2:0]  zfunc = '0;
  logic        wr_en = 1'b0, blend_en = 1'b0, stencil_en = 1'b0;
  logic        clear = 1'b0;
  logic [15:0] clear_val = '0;
  logic        busy, resp_valid, discard;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lrz_unit u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .req_valid_i  (req_valid),
    .req_ready_o  (req_ready),
    .tile_x_i     (tile_x),
    .tile_y_i     (tile_y),
    .zmin_i       (zmin),
    .zmax_i       (zmax),
    .full_cover_i (full_cover),
    .zfunc_i      (zfunc),
    .wr_en_i      (wr_en),
    .blend_en_i   (blend_en),
    .stencil_en_i (stencil_en),
    .clear_i      (clear),
    .clear_val_i  (clear_val),
    .busy_o       (busy),
    .resp_valid_o (resp_valid),
    .discard_o    (discard)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    req_valid  = 1'b1;
    tile_x     = v.x;
    tile_y     = v.y;
    zmin       = v.zmin;
    zmax       = v.zmax;
    full_cover = v.full;
    zfunc      = v.fn;
    wr_en      = v.wr;
    blend_en   = v.blend;
    stencil_en = v.sten;
  endtask

  task automatic send(input vec_t v, input int idx);
    @(negedge clk);
    drive(v);
    chk($sformatf("R9 ready before vector %0d", idx), req_ready, 1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk($sformatf("R2 no early response vector %0d", idx), resp_valid, 0);
    @(negedge clk);
    chk($sformatf("R2 response due vector %0d", idx), resp_valid, 1);
    chk($sformatf("R4 R5 R6 R7 R8 R3 R11 decision vector %0d", idx), discard, v.exp_disc);
  endtask

  task automatic do_clear(input logic [15:0] val);
    int cyc;
    @(negedge clk);
    clear = 1'b1;
    clear_val = val;
    #1;
    chk("R9 ready low with clear", req_ready, 0);
    @(posedge clk);
    @(negedge clk);
    clear = 1'b0;
    cyc = 0;
    while (busy && cyc < 4 * DEPTH) begin
      if (cyc == 1) chk("R9 ready low while busy", req_ready, 0);
      cyc++;
      @(negedge clk);
    end
    chk("R9 busy length", cyc, DEPTH);
    chk("R9 ready after clear", req_ready, 1);
  endtask

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      report();
      $finish;
    end
  end

  initial begin
    vec_t a, b;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", busy, 0);
    chk("R1 resp_valid in reset", resp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", req_ready, 1);
    chk("R1 busy after reset", busy, 0);
    chk("R1 resp_valid after reset", resp_valid, 0);

    do_clear(16'h8000);
    for (int i = 0; i < NV; i++) send(VECS[i], i);

    // R6 saturation: ceil of FFFF01 must stay FFFF, not wrap
    do_clear(16'hFFFF);
    send('{6'd3, 2'd0, 24'h100000, 24'hFFFF01, 1'b1, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0}, 100);
    send('{6'd3, 2'd0, 24'h800000, 24'h800000, 1'b0, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0}, 101);

    // R10 back-to-back on one tile
    a = '{6'd5, 2'd2, 24'h100000, 24'h200000, 1'b1, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0};
    b = '{6'd5, 2'd2, 24'h300000, 24'h300000, 1'b0, 3'd1, 1'b1, 1'b0, 1'b0, 1'b1};
    @(negedge clk);
    drive(a);
    @(posedge clk);
    @(negedge clk);
    drive(b);
    chk("R2 no early response first of pair", resp_valid, 0);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 first of pair due", resp_valid, 1);
    chk("R10 first of pair passes", discard, 0);
    @(negedge clk);
    chk("R2 second of pair due", resp_valid, 1);
    chk("R10 second sees forwarded bound", discard, 1);
    @(negedge clk);
    chk("R2 no extra response", resp_valid, 0);

    done = 1'b1;
    report();
    $finish;
  end
endmodule